// File: doc/BRIEF.md
# Loopback and Test Mode Controller

This block sits between the terminal-side digital rails and the line-side digital rails of a line interface. It carries the transmit rails from the terminal to the line and the receive rails from the slicer to the terminal. It also carries the loss-of-signal flag from the detector to the terminal. Two asynchronous select inputs choose one of four modes. In normal mode the two paths run independently. In local loopback, the data sent to the line is turned back into the receive side. In remote loopback, the recovered receive data is sent back out on the line. When both selects are high, every output is released to high impedance for in-circuit test.

The selects pass through a two-flop synchronizer. A small state machine then adopts the synchronized value, but only on a cycle where the bit-clock strobe `bit_en` is high. This way a mode change never cuts a bit in half. The state machine has four states: NORMAL, LOCAL, REMOTE and TEST. Every state can move straight to every other state. The move happens on a `bit_en` cycle, and the target is the synchronized select pair: 00 goes to NORMAL, 01 (local only) to LOCAL, 10 (remote only) to REMOTE, and 11 to TEST. When `bit_en` is low, the state holds. Each output group has an enable, and the enable drops in TEST. All data outputs are registered and have one cycle of latency.

Top module: `lbk_mode_ctrl`

## Requirements
- R1: In LOCAL, the line outputs and the terminal receive outputs both carry the terminal transmit rails, and the slicer rails have no effect on any output.
- R2: In LOCAL, the loss-of-signal output reads 0 whatever the detector input is.
- R3: In REMOTE, the line outputs carry the slicer rails, and the terminal transmit rails have no effect on any output.
- R4: In REMOTE, the terminal receive outputs still carry the slicer rails, and the loss-of-signal output follows the detector input.
- R5: In TEST, all three output enables are 0 and all data outputs are driven 0.
- R6: In NORMAL, the line outputs carry the terminal transmit rails, the terminal receive outputs carry the slicer rails, and the loss-of-signal output follows the detector.
- R7: A select change reaches the mode state three clock edges after it is applied when `bit_en` is high, and is first visible on `mode_status` after that third edge. While `bit_en` is low, the mode holds.
- R8: `mode_status` is registered and encodes NORMAL=2'b00, LOCAL=2'b01, REMOTE=2'b10, TEST=2'b11. Bit 0 is the local select and bit 1 is the remote select.
- R9: While reset is active, `mode_status` is 00, all data outputs are 0 and all enables are 1.
- R10: Each data output shows the value its source had one clock edge earlier. The mode used is the one in force at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit-clock strobe; the mode may change only on cycles where this is high |
| lb_local_sel | input | 1 | Asynchronous local loopback select |
| lb_remote_sel | input | 1 | Asynchronous remote loopback select |
| term_tx_pos | input | 1 | Terminal transmit positive rail |
| term_tx_neg | input | 1 | Terminal transmit negative rail |
| slc_rx_pos | input | 1 | Slicer recovered positive rail |
| slc_rx_neg | input | 1 | Slicer recovered negative rail |
| slc_los | input | 1 | Loss-of-signal flag from the detector |
| line_tx_pos | output | 1 | Line-side transmit positive rail |
| line_tx_neg | output | 1 | Line-side transmit negative rail |
| line_tx_oe | output | 1 | Output enable for the line-side rails |
| term_rx_pos | output | 1 | Terminal receive positive rail |
| term_rx_neg | output | 1 | Terminal receive negative rail |
| term_rx_oe | output | 1 | Output enable for the terminal receive rails |
| los_out | output | 1 | Loss-of-signal output |
| los_oe | output | 1 | Output enable for the loss-of-signal output |
| mode_status | output | 2 | Registered current mode |

## Verification
In remote loopback, one slicer sample goes out in the same cycle on both the line rails and the terminal receive rails. In local loopback, one terminal sample likewise fans out to both sides. The bench provokes this by driving different bit patterns on the terminal and slicer rails in the same cycle. A scoreboard then judges, for each cycle's output, which source reached each side. Mode changes are also requested while data keeps flowing with the strobe held low. The scoreboard expects the old routing until the strobe returns.

// File: rtl/lbk_pkg.sv
package lbk_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_LOCAL  = 2'b01,
        MODE_REMOTE = 2'b10,
        MODE_TEST   = 2'b11
    } lbk_mode_e;

    typedef struct packed {
        logic pos;
        logic neg;
    } rail_pair_t;

    localparam int SEL_W = 2;

endpackage

// File: rtl/lbk_sel_sync.sv
module lbk_sel_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q <= '0;
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], async_i[b]};
                end
            end
            assign sync_o[b] = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/lbk_mode_fsm.sv
module lbk_mode_fsm
    import lbk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en_i,
    input  logic [SEL_W-1:0] sel_i,
    output lbk_mode_e        mode_o,
    output logic             loop_local_o,
    output logic             loop_remote_o,
    output logic             hiz_o
);

    lbk_mode_e state_q;
    lbk_mode_e state_d;

    always_comb begin
        state_d = state_q;
        if (bit_en_i) begin
            unique case (sel_i)
                2'b00:   state_d = MODE_NORMAL;
                2'b01:   state_d = MODE_LOCAL;
                2'b10:   state_d = MODE_REMOTE;
                default: state_d = MODE_TEST;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_NORMAL;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        mode_o        = state_q;
        loop_local_o  = 1'b0;
        loop_remote_o = 1'b0;
        hiz_o         = 1'b0;
        unique case (state_q)
            MODE_NORMAL: ;
            MODE_LOCAL:  loop_local_o  = 1'b1;
            MODE_REMOTE: loop_remote_o = 1'b1;
            MODE_TEST:   hiz_o         = 1'b1;
        endcase
    end

    // R7: without a strobe the mode never moves
    assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en_i |=> $stable(state_q));

    // R8: at most one routing flag at a time
    assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({loop_local_o, loop_remote_o, hiz_o}));

endmodule

// File: rtl/lbk_router.sv
module lbk_router
    import lbk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       loop_local_i,
    input  logic       loop_remote_i,
    input  logic       hiz_i,
    input  rail_pair_t term_tx_i,
    input  rail_pair_t slc_rx_i,
    input  logic       slc_los_i,
    output rail_pair_t line_tx_o,
    output rail_pair_t term_rx_o,
    output logic       los_o,
    output logic       oe_o
);

    rail_pair_t tx_src;
    rail_pair_t rx_src;
    logic       los_d;
    logic       oe_d;

    always_comb begin
        tx_src = term_tx_i;
        rx_src = slc_rx_i;
        los_d  = slc_los_i;
        oe_d   = 1'b1;
        if (hiz_i) begin
            tx_src = '0;
            rx_src = '0;
            los_d  = 1'b0;
            oe_d   = 1'b0;
        end else if (loop_local_i) begin
            rx_src = term_tx_i;
            los_d  = 1'b0;
        end else if (loop_remote_i) begin
            tx_src = slc_rx_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_tx_o <= '0;
            term_rx_o <= '0;
            los_o     <= 1'b0;
            oe_o      <= 1'b1;
        end else begin
            line_tx_o <= tx_src;
            term_rx_o <= rx_src;
            los_o     <= los_d;
            oe_o      <= oe_d;
        end
    end

    assert_local_loop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        loop_local_i |=> (term_rx_o == $past(term_tx_i)) && (line_tx_o == $past(term_tx_i)));

    assert_local_los_R2: assert property (@(posedge clk) disable iff (!rst_n)
        loop_local_i |=> !los_o);

    assert_remote_loop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        loop_remote_i |=> (line_tx_o == $past(slc_rx_i)) && (term_rx_o == $past(slc_rx_i)));

    assert_test_hiz_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hiz_i |=> !oe_o && (line_tx_o == '0) && (term_rx_o == '0) && !los_o);

    assert_normal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(hiz_i || loop_local_i || loop_remote_i) |=>
            (line_tx_o == $past(term_tx_i)) && (term_rx_o == $past(slc_rx_i)) && (los_o == $past(slc_los_i)));

endmodule

// File: rtl/lbk_mode_ctrl.sv
module lbk_mode_ctrl
    import lbk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       lb_local_sel,
    input  logic       lb_remote_sel,
    input  logic       term_tx_pos,
    input  logic       term_tx_neg,
    input  logic       slc_rx_pos,
    input  logic       slc_rx_neg,
    input  logic       slc_los,
    output logic       line_tx_pos,
    output logic       line_tx_neg,
    output logic       line_tx_oe,
    output logic       term_rx_pos,
    output logic       term_rx_neg,
    output logic       term_rx_oe,
    output logic       los_out,
    output logic       los_oe,
    output logic [1:0] mode_status
);

    logic [SEL_W-1:0] sel_sync;
    lbk_mode_e        mode;
    logic             loop_local;
    logic             loop_remote;
    logic             hiz;
    rail_pair_t       line_tx;
    rail_pair_t       term_rx;
    logic             oe;

    lbk_sel_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (SEL_W)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({lb_remote_sel, lb_local_sel}),
        .sync_o  (sel_sync)
    );

    lbk_mode_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_en_i      (bit_en),
        .sel_i         (sel_sync),
        .mode_o        (mode),
        .loop_local_o  (loop_local),
        .loop_remote_o (loop_remote),
        .hiz_o         (hiz)
    );

    lbk_router u_router (
        .clk           (clk),
        .rst_n         (rst_n),
        .loop_local_i  (loop_local),
        .loop_remote_i (loop_remote),
        .hiz_i         (hiz),
        .term_tx_i     ('{pos: term_tx_pos, neg: term_tx_neg}),
        .slc_rx_i      ('{pos: slc_rx_pos, neg: slc_rx_neg}),
        .slc_los_i     (slc_los),
        .line_tx_o     (line_tx),
        .term_rx_o     (term_rx),
        .los_o         (los_out),
        .oe_o          (oe)
    );

    assign line_tx_pos = line_tx.pos;
    assign line_tx_neg = line_tx.neg;
    assign term_rx_pos = term_rx.pos;
    assign term_rx_neg = term_rx.neg;
    assign line_tx_oe  = oe;
    assign term_rx_oe  = oe;
    assign los_oe      = oe;
    assign mode_status = mode;

endmodule

// File: tb/lbk_mode_ctrl_tb.sv
module lbk_mode_ctrl_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b1;
    logic lsel = 1'b0, rsel = 1'b0;
    logic tp = 1'b0, tn = 1'b0, rp = 1'b0, rn = 1'b0, ls = 1'b0;
    logic line_tx_pos, line_tx_neg, line_tx_oe, term_rx_pos, term_rx_neg, term_rx_oe;
    logic los_out, los_oe;
    logic [1:0] mode_status;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [1:0] cur_mode = 2'b00;
    logic [9:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    lbk_mode_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
        .lb_local_sel(lsel), .lb_remote_sel(rsel),
        .term_tx_pos(tp), .term_tx_neg(tn),
        .slc_rx_pos(rp), .slc_rx_neg(rn), .slc_los(ls),
        .line_tx_pos(line_tx_pos), .line_tx_neg(line_tx_neg), .line_tx_oe(line_tx_oe),
        .term_rx_pos(term_rx_pos), .term_rx_neg(term_rx_neg), .term_rx_oe(term_rx_oe),
        .los_out(los_out), .los_oe(los_oe), .mode_status(mode_status)
    );

    function automatic logic [9:0] snapshot();
        return {line_tx_pos, line_tx_neg, line_tx_oe, term_rx_pos, term_rx_neg, term_rx_oe,
                los_out, los_oe, mode_status};
    endfunction

    // expected outputs from the requirements; packing matches snapshot()
    function automatic logic [9:0] model(logic [1:0] m, logic a, logic b, logic c, logic d, logic l);
        case (m)
            2'b00:   return {a, b, 1'b1, c, d, 1'b1, l,    1'b1, m};
            2'b01:   return {a, b, 1'b1, a, b, 1'b1, 1'b0, 1'b1, m};
            2'b10:   return {c, d, 1'b1, c, d, 1'b1, l,    1'b1, m};
            default: return {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, m};
        endcase
    endfunction

    task automatic check(bit ok, string tag, logic [9:0] act, logic [9:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // driver: apply one bit on all inputs and queue the expected result
    task automatic drive(logic a, logic b, logic c, logic d, logic l, string tag);
        @(negedge clk);
        tp = a; tn = b; rp = c; rn = d; ls = l;
        exp_q.push_back(model(cur_mode, a, b, c, d, l));
        tag_q.push_back(tag);
    endtask

    // monitor: outputs registered at the edge after the drive
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [9:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(snapshot() == e, t, snapshot(), e);
            end
        end
    end

    task automatic set_mode(logic loc, logic rem);
        logic [1:0] nm;
        nm = {rem, loc};
        @(negedge clk);
        lsel = loc; rsel = rem;
        repeat (2) @(posedge clk);
        #1 check(mode_status == cur_mode, "R7 mode before third edge", {8'b0, mode_status}, {8'b0, cur_mode});
        @(posedge clk);
        #1 check(mode_status == nm, "R8 mode after third edge", {8'b0, mode_status}, {8'b0, nm});
        cur_mode = nm;
        @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 check(snapshot() == 10'b0010010100, "R9 reset state", snapshot(), 10'b0010010100);
        @(negedge clk);
        rst_n = 1'b1;

        drive(1, 0, 0, 1, 0, "R6 normal a");
        drive(0, 1, 1, 0, 1, "R6 normal b");
        drive(1, 0, 1, 0, 0, "R10 latency");
        drive(0, 0, 0, 0, 1, "R6 normal los");

        set_mode(1'b1, 1'b0);
        drive(1, 0, 0, 1, 1, "R1 local a");
        drive(0, 1, 1, 0, 1, "R2 local los ignored");
        drive(0, 0, 1, 1, 0, "R1 local slicer ignored");

        set_mode(1'b0, 1'b1);
        drive(1, 0, 0, 1, 1, "R3 remote a");
        drive(0, 1, 1, 0, 0, "R4 remote b");
        drive(1, 1, 0, 0, 1, "R3 terminal ignored");

        set_mode(1'b1, 1'b1);
        drive(1, 0, 0, 1, 1, "R5 test a");
        drive(1, 1, 1, 1, 1, "R5 test b");

        set_mode(1'b0, 1'b0);
        drive(1, 0, 0, 1, 1, "R6 back to normal");

        // strobe low: mode must hold while data keeps flowing
        @(negedge clk);
        bit_en = 1'b0;
        lsel = 1'b0; rsel = 1'b1;
        for (int i = 0; i < 6; i++) drive(i[0], ~i[0], ~i[0], i[0], i[1], "R7 hold without strobe");
        #3 check(mode_status == 2'b00, "R7 held mode", {8'b0, mode_status}, 10'b0);
        @(negedge clk);
        bit_en = 1'b1;
        @(posedge clk);
        #1 check(mode_status == 2'b10, "R7 strobe adopts", {8'b0, mode_status}, 10'b10);
        cur_mode = 2'b10;
        drive(0, 1, 1, 0, 1, "R4 after strobe");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule